// File: doc/BRIEF.md
# Vector Floating-Point Exception Flag Collector

This block gathers the IEEE exception flags produced by a 32-lane half-precision fused multiply-add pipeline and folds them into four sticky status bits: invalid, overflow, underflow and inexact. Each status bit is the OR of that flag across all lanes the predicate mask keeps. The op-class of the instruction decides which of the four flags it may report at all. The control-register enables decide whether a newly raised flag also raises a deferred imprecise-error pulse.

An instruction is seen twice. At the issue point (stage 3) the block samples the op-class and the coprocessor enable. A disabled coprocessor squashes the op and raises an exception pulse, and the op then has no flag effect. A surviving op is tracked down an internal delay line until the result point (stage 13). There the datapath presents the per-lane flag vectors and the lane predicate. The status bits change at stage 14 and the imprecise-error pulse appears at stage 15. Software may overwrite the status bits through a write port, and that write wins over a flag update in the same cycle.

Top module: `vfp_flag_collector`

## Requirements
- R1: After reset the status bits are 0000 and the exception and imprecise-error outputs are low.
- R2: Status bits are {invalid, overflow, underflow, inexact} at bits [3:0]. A bit is set when any kept lane raises that flag, and it stays set until a software write.
- R3: A lane whose `lane_keep` bit is 0 contributes no flag.
- R4: The op-class codes are 0 add, 1 subtract, 2 multiply, 3 multiply-add, 4 multiply-subtract, 5 one-minus-product, 6 division step and 7 no-flag. Add and subtract never set the underflow bit.
- R5: The division step never sets the invalid bit. It reports overflow, underflow and inexact.
- R6: The no-flag class changes no status bit and never raises the imprecise error.
- R7: Multiply, multiply-add, multiply-subtract and one-minus-product report all four flags.
- R8: An issue with `iss_cp_en` low gives a one-cycle `cp_exc` pulse in the cycle after issue. That op has no later effect on status or on the imprecise error.
- R9: The lane flags of an op are taken 10 cycles after its issue (stage 13), and the status bits show them one cycle later (stage 14).
- R10: `imp_err` is a one-cycle pulse one cycle after the status update (stage 15). It is raised only when a flag that the class may report and that `fcr_en` enables goes from 0 to 1 in that update. `fcr_en` is sampled in the same cycle as the lane flags.
- R11: When `sw_wr` is high the status bits load `sw_data` on the next cycle. Any flag update in the same cycle is discarded and raises no imprecise error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An op reaches the issue stage |
| iss_cls | input | 3 | Op-class code of the issuing op |
| iss_cp_en | input | 1 | Coprocessor enable sampled at issue |
| lane_inv | input | 32 | Per-lane invalid flags at the result stage |
| lane_ovf | input | 32 | Per-lane overflow flags at the result stage |
| lane_unf | input | 32 | Per-lane underflow flags at the result stage |
| lane_inx | input | 32 | Per-lane inexact flags at the result stage |
| lane_keep | input | 32 | Per-lane predicate, 1 = lane kept |
| fcr_en | input | 4 | Imprecise-error enables, same bit order as status |
| sw_wr | input | 1 | Software write strobe for the status bits |
| sw_data | input | 4 | Value written to the status bits |
| status | output | 4 | Sticky {invalid, overflow, underflow, inexact} |
| cp_exc | output | 1 | Coprocessor-disabled exception pulse |
| imp_err | output | 1 | Deferred imprecise-error pulse |

## Verification
The bench covers several corner cases. Flags land on the edge lanes 0 and 31, so a design that ORs only part of the vector misses them. A flag raised only on a killed lane must leave status clear; a design that ignores the predicate would set the bit. Add and subtract must drop underflow and the division step must drop invalid; a design with one shared mask would set those bits. A squashed op sends flags at its result slot that must stay out of status. A flag that is already set must not pulse `imp_err` again, which catches a design that compares against the lane flags instead of the old status. A software write landing in the flag cycle must win, so a design with the wrong priority would show the OR of both values.

// File: rtl/vfp_flag_collector.sv
module vfp_flag_collector #(
  parameter int LANES        = 32,
  parameter int ISSUE_STAGE  = 3,
  parameter int RESULT_STAGE = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [2:0]       iss_cls,
  input  logic             iss_cp_en,
  input  logic [LANES-1:0] lane_inv,
  input  logic [LANES-1:0] lane_ovf,
  input  logic [LANES-1:0] lane_unf,
  input  logic [LANES-1:0] lane_inx,
  input  logic [LANES-1:0] lane_keep,
  input  logic [3:0]       fcr_en,
  input  logic             sw_wr,
  input  logic [3:0]       sw_data,
  output logic [3:0]       status,
  output logic             cp_exc,
  output logic             imp_err
);
  localparam int DEPTH = RESULT_STAGE - ISSUE_STAGE;

  logic [DEPTH-1:0] pv;
  logic [2:0]       pc [DEPTH];
  logic [3:0]       status_q, cmask, raw, hit, fresh;
  logic             imp_s14, imp_q, cp_q;

  wire       res_valid = pv[DEPTH-1];
  wire [2:0] res_cls   = pc[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < DEPTH; i++) pc[i] <= '0;
    end else begin
      pv    <= {pv[DEPTH-2:0], iss_valid & iss_cp_en};
      pc[0] <= iss_cls;
      for (int i = 1; i < DEPTH; i++) pc[i] <= pc[i-1];
    end
  end

  always_comb begin
    case (res_cls)
      3'd0, 3'd1: cmask = 4'b1101;
      3'd6:       cmask = 4'b0111;
      3'd7:       cmask = 4'b0000;
      default:    cmask = 4'b1111;
    endcase
  end

  assign raw   = {|(lane_inv & lane_keep), |(lane_ovf & lane_keep),
                  |(lane_unf & lane_keep), |(lane_inx & lane_keep)};
  assign hit   = res_valid ? (raw & cmask) : 4'b0000;
  assign fresh = hit & ~status_q & fcr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      imp_s14  <= 1'b0;
      imp_q    <= 1'b0;
      cp_q     <= 1'b0;
    end else begin
      status_q <= sw_wr ? sw_data : (status_q | hit);
      imp_s14  <= ~sw_wr & (|fresh);
      imp_q    <= imp_s14;
      cp_q     <= iss_valid & ~iss_cp_en;
    end
  end

  assign status  = status_q;
  assign cp_exc  = cp_q;
  assign imp_err = imp_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((status & $past(status)) == $past(status)));

  // R11
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (status == $past(sw_data)));

  // R8
  cp_exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_exc |-> $past(iss_valid && !iss_cp_en));

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !res_valid) |=> (status == $past(status)));

  // R10
  imp_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imp_err |-> (($past(status) & ~$past(status, 2)) != 4'b0000));
endmodule

// File: tb/test_vfp_flag_collector.sv
module test_vfp_flag_collector;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iss_valid = 1'b0, iss_cp_en = 1'b0, sw_wr = 1'b0;
  logic [2:0]  iss_cls = '0;
  logic [31:0] lane_inv = '0, lane_ovf = '0, lane_unf = '0, lane_inx = '0, lane_keep = '0;
  logic [3:0]  fcr_en = '0, sw_data = '0;
  logic [3:0]  status;
  logic        cp_exc, imp_err;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  vfp_flag_collector i_vfp_flag_collector (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_cp_en(iss_cp_en), .lane_inv(lane_inv), .lane_ovf(lane_ovf),
    .lane_unf(lane_unf), .lane_inx(lane_inx), .lane_keep(lane_keep),
    .fcr_en(fcr_en), .sw_wr(sw_wr), .sw_data(sw_data),
    .status(status), .cp_exc(cp_exc), .imp_err(imp_err));

  // {cls[2:0], cp_en, fcr[3:0], flags[3:0], lane[4:0], kill}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 1'b1, 4'hF, 4'hF, 5'd0,  1'b0},
    {3'd1, 1'b1, 4'h0, 4'h2, 5'd5,  1'b0},
    {3'd2, 1'b1, 4'hF, 4'hF, 5'd31, 1'b0},
    {3'd3, 1'b1, 4'h0, 4'hA, 5'd16, 1'b0},
    {3'd4, 1'b1, 4'h4, 4'h6, 5'd7,  1'b0},
    {3'd5, 1'b1, 4'h1, 4'h1, 5'd9,  1'b1},
    {3'd6, 1'b1, 4'hF, 4'hF, 5'd2,  1'b0},
    {3'd6, 1'b1, 4'h8, 4'h8, 5'd3,  1'b0},
    {3'd7, 1'b1, 4'hF, 4'hF, 5'd4,  1'b0},
    {3'd2, 1'b0, 4'hF, 4'hF, 5'd6,  1'b0},
    {3'd3, 1'b1, 4'h1, 4'h1, 5'd31, 1'b1}
  };

  function automatic logic [3:0] class_mask(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 4'b1101;
      3'd6:       return 4'b0111;
      3'd7:       return 4'b0000;
      default:    return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [3:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_data = d;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] c, input logic cpen, input logic [3:0] fe,
                        input logic [31:0] vi, vo, vu, vx, kp,
                        input logic sw, input logic [3:0] swd,
                        output logic ce, output logic [3:0] pre);
    @(negedge clk); iss_valid = 1'b1; iss_cls = c; iss_cp_en = cpen;
    @(negedge clk); iss_valid = 1'b0; iss_cp_en = 1'b0; ce = cp_exc;
    repeat (9) @(negedge clk);
    pre = status;
    lane_inv = vi; lane_ovf = vo; lane_unf = vu; lane_inx = vx; lane_keep = kp;
    fcr_en = fe; sw_wr = sw; sw_data = swd;
    @(negedge clk);
    lane_inv = '0; lane_ovf = '0; lane_unf = '0; lane_inx = '0; lane_keep = '0;
    fcr_en = '0; sw_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ce;
    logic [3:0] pre, ef, st, ex;
    logic [31:0] one;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 4'h0);
    chk("R1 cp_exc", {3'b0, cp_exc}, 4'h0);
    chk("R1 imp_err", {3'b0, imp_err}, 4'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [17:0] v;
      v = VEC[k];
      sw_write(4'h0);
      chk("R11 clear", status, 4'h0);
      ef  = v[9:6];
      one = 32'd1 << v[5:1];
      run_op(v[17:15], v[14], v[13:10],
             ef[3] ? one : 32'd0, ef[2] ? one : 32'd0,
             ef[1] ? one : 32'd0, ef[0] ? one : 32'd0,
             v[0] ? ~one : 32'hFFFF_FFFF, 1'b0, 4'h0, ce, pre);
      st = (v[14] && !v[0]) ? (ef & class_mask(v[17:15])) : 4'h0;
      ex = {3'b0, |(st & v[13:10])};
      // R8 exception pulse; R3 R4 R5 R6 R7 masks; R9 timing
      chk("R8 cp_exc", {3'b0, ce}, {3'b0, ~v[14]});
      chk("R9 pre-update status", pre, 4'h0);
      chk("R2 R3 R4 R5 R6 R7 status", status, st);
      chk("R10 imp not early", {3'b0, imp_err}, 4'h0);
      @(negedge clk);
      chk("R10 imp pulse", {3'b0, imp_err}, ex);
      @(negedge clk);
      chk("R10 imp one cycle", {3'b0, imp_err}, 4'h0);
    end

    // R2 R10: sticky accumulation, pulse only on a newly set bit
    sw_write(4'h0);
    run_op(3'd2, 1'b1, 4'hF, 32'h8000_0001, 0, 0, 0, 32'hFFFF_FFFF, 1'b0, 4'h0, ce, pre);
    chk("R2 first", status, 4'h8);
    @(negedge clk); chk("R10 first imp", {3'b0, imp_err}, 4'h1);
    run_op(3'd2, 1'b1, 4'hF, 32'h0000_0010, 0, 0, 32'h0000_0100, 32'hFFFF_FFFF, 1'b0, 4'h0, ce, pre);
    chk("R2 accumulate", status, 4'h9);
    @(negedge clk); chk("R10 new inexact imp", {3'b0, imp_err}, 4'h1);
    run_op(3'd3, 1'b1, 4'hF, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'h0, ce, pre);
    chk("R2 held", status, 4'h9);
    @(negedge clk); chk("R10 no repeat imp", {3'b0, imp_err}, 4'h0);

    // R11: software write wins over a same-cycle flag update
    sw_write(4'h0);
    run_op(3'd2, 1'b1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
           32'hFFFF_FFFF, 1'b1, 4'h4, ce, pre);
    chk("R11 priority", status, 4'h4);
    @(negedge clk); chk("R11 no imp", {3'b0, imp_err}, 4'h0);
    sw_write(4'hA);
    chk("R11 set", status, 4'hA);
    repeat (3) @(negedge clk);
    chk("R2 idle hold", status, 4'hA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule